// File: doc/BRIEF.md
# Call/Return Context Save Sequencer

This block moves a processor's whole architectural context to and from a stack in memory in hardware, so that procedure calls, procedure returns and interrupt entry do not need a software save and restore sequence. It owns the program counter and the stack pointer. It reaches the general-purpose register file through one read/write port and memory through a single-word request/acknowledge port that carries one access at a time.

A call writes a frame of sixteen 64-bit words below the stack pointer. The frame holds the return address first, then general-purpose registers 1 to 15. The stack pointer then drops by the frame size and the program counter jumps to the call target. A return reads the frame back from the top of the stack in reverse order, writes the registers back, reloads the program counter and raises the stack pointer again. An interrupt saves the same frame as a call. It then fetches the handler address from a fixed vector word in memory. The surrounding core loads the program counter and stack pointer through a load strobe while the block is idle. It pulses a start input for each operation and waits for the one-cycle done pulse.

Top module: `ctx_seq`

## Requirements
- R1: A call or interrupt writes 16 words: word 0 is the saved PC at address SP-8, then register i (i = 1..15) at SP-8*(i+1), in that order, one access per acknowledge.
- R2: The PC saved by a call is the current PC plus `call_len`. The PC saved by an interrupt is the current PC unchanged.
- R3: When a call completes, `sp_o` equals the old SP minus 128 and `pc_o` equals `call_target`.
- R4: A return reads address SP+8*j for j = 0..15 in order. Word j (j < 15) is written to register 15-j, word 15 becomes `pc_o`, and `sp_o` rises by 128. A register-file write happens only on an acknowledged read.
- R5: An interrupt performs the save of R1 and moves SP down by 128. It then reads the word at `VEC_ADDR` (default 0x0), and that word becomes `pc_o`.
- R6: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until `mem_ack` is seen.
- R7: `done` is high for exactly one cycle when an operation ends. Start inputs that arrive while an operation is in progress are ignored and cause no memory access.
- R8: If `irq_req` and `call_start` are both high in the same idle cycle, the interrupt runs first. The call then runs after the interrupt's `done`, saving the handler PC plus `call_len`.
- R9: If SP has any of its low 3 bits set when an operation starts, `done` and `err` pulse together one cycle later. No memory access is made, and PC and SP keep their values.
- R10: `arch_load` in an idle cycle with no start sets `pc_o` to `arch_pc` and `sp_o` to `arch_sp`. After reset both are zero, and `done`, `err` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arch_load | input | 1 | Load PC and SP from the next two ports (idle only) |
| arch_pc | input | 64 | PC value to load |
| arch_sp | input | 64 | SP value to load |
| call_start | input | 1 | Start a call |
| call_target | input | 64 | Call destination address |
| call_len | input | 4 | Byte length of the calling instruction |
| ret_start | input | 1 | Start a return |
| irq_req | input | 1 | Interrupt entry request |
| rf_addr | output | 4 | Register-file index (1..15) |
| rf_rdata | input | 64 | Register-file read data for `rf_addr` |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | 64 | Register-file write data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address of the word |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |
| pc_o | output | 64 | Program counter |
| sp_o | output | 64 | Stack pointer |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Misaligned-SP error, pulsed with `done` |

## Verification
Embedded properties check on every cycle that a memory request and its address and data hold until acknowledged, and that every request address is word-aligned. They also check that `done` never lasts two cycles, that a misaligned start yields an error with no request, and that a register-file write coincides with an acknowledged read. In the same cycle collision of interrupt and call, they check that the interrupt is the one taken first. The frame layout, the values written, the PC and SP after each operation, the deferred call after an interrupt, and the absence of any access for starts raised while busy are shown only by the bench's scenarios. In those scenarios a scoreboard matches every memory access against the sequence the requirements predict.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    typedef enum logic [1:0] {
        OP_CALL = 2'd0,
        OP_RET  = 2'd1,
        OP_IRQ  = 2'd2
    } ctx_op_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SAVE = 3'd1,
        ST_VEC  = 3'd2,
        ST_LOAD = 3'd3,
        ST_FIN  = 3'd4,
        ST_ERR  = 3'd5
    } ctx_state_e;

    // Operations that write a frame to the stack
    function automatic logic op_saves(input ctx_op_e op);
        return (op == OP_CALL) || (op == OP_IRQ);
    endfunction

endpackage

// File: rtl/ctx_start_arb.sv
module ctx_start_arb
    import ctx_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle,
    input  logic             irq_req,
    input  logic             call_start,
    input  logic             ret_start,
    input  logic [XLEN-1:0]  call_target,
    input  logic [LEN_W-1:0] call_len,
    output logic             go,
    output ctx_op_e          go_op,
    output logic [XLEN-1:0]  go_tgt,
    output logic [LEN_W-1:0] go_len
);

    logic             pend_q;
    ctx_op_e          pend_op_q;
    logic [XLEN-1:0]  pend_tgt_q;
    logic [LEN_W-1:0] pend_len_q;

    logic collide;
    assign collide = idle && !pend_q && irq_req && (call_start || ret_start);

    always_comb begin
        go     = 1'b0;
        go_op  = OP_CALL;
        go_tgt = call_target;
        go_len = call_len;
        if (idle) begin
            if (pend_q) begin
                go     = 1'b1;
                go_op  = pend_op_q;
                go_tgt = pend_tgt_q;
                go_len = pend_len_q;
            end else if (irq_req) begin
                go    = 1'b1;
                go_op = OP_IRQ;
            end else if (call_start) begin
                go    = 1'b1;
                go_op = OP_CALL;
            end else if (ret_start) begin
                go    = 1'b1;
                go_op = OP_RET;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            pend_op_q  <= OP_CALL;
            pend_tgt_q <= '0;
            pend_len_q <= '0;
        end else if (collide) begin
            pend_q     <= 1'b1;
            pend_op_q  <= call_start ? OP_CALL : OP_RET;
            pend_tgt_q <= call_target;
            pend_len_q <= call_len;
        end else if (idle && pend_q) begin
            pend_q <= 1'b0;
        end
    end

    AST_PEND_IS_DEFERRED: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> !(go && go_op == OP_IRQ)) else $error("deferred start lost priority"); // R8

endmodule

// File: rtl/ctx_frame_addr.sv
module ctx_frame_addr #(
    parameter int XLEN     = 64,
    parameter int IDX_W    = 4,
    parameter int WB_SHIFT = 3
) (
    input  logic [XLEN-1:0]  sp,
    input  logic [IDX_W-1:0] idx,
    input  logic             upward,
    output logic [XLEN-1:0]  addr
);

    logic [IDX_W:0]   slot;
    logic [XLEN-1:0]  offset;

    always_comb begin
        // Saving walks down from SP-8, restoring walks up from SP
        slot   = upward ? {1'b0, idx} : ({1'b0, idx} + (IDX_W+1)'(1));
        offset = XLEN'(slot) << WB_SHIFT;
        addr   = upward ? (sp + offset) : (sp - offset);
    end

endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
    import ctx_pkg::*;
#(
    parameter int               XLEN     = 64,
    parameter int               NREG     = 15,
    parameter int               LEN_W    = 4,
    parameter logic [XLEN-1:0]  VEC_ADDR = '0,
    localparam int              RF_AW    = $clog2(NREG + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arch_load,
    input  logic [XLEN-1:0]  arch_pc,
    input  logic [XLEN-1:0]  arch_sp,
    input  logic             call_start,
    input  logic [XLEN-1:0]  call_target,
    input  logic [LEN_W-1:0] call_len,
    input  logic             ret_start,
    input  logic             irq_req,
    output logic [RF_AW-1:0] rf_addr,
    input  logic [XLEN-1:0]  rf_rdata,
    output logic             rf_we,
    output logic [XLEN-1:0]  rf_wdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    input  logic             mem_ack,
    output logic [XLEN-1:0]  pc_o,
    output logic [XLEN-1:0]  sp_o,
    output logic             done,
    output logic             err
);

    localparam int              WORD_BYTES  = XLEN / 8;
    localparam int              WB_SHIFT    = $clog2(WORD_BYTES);
    localparam int              FRAME_WORDS = NREG + 1;
    localparam logic [XLEN-1:0] FRAME_BYTES = XLEN'(FRAME_WORDS * WORD_BYTES);
    localparam logic [RF_AW-1:0] LAST_IDX   = RF_AW'(NREG);

    ctx_state_e       state_q;
    ctx_op_e          op_q;
    logic [RF_AW-1:0] idx_q;
    logic [XLEN-1:0]  tgt_q, ret_pc_q, pc_q, sp_q;

    logic             idle, misaligned;
    logic             arb_go;
    ctx_op_e          arb_op;
    logic [XLEN-1:0]  arb_tgt;
    logic [LEN_W-1:0] arb_len;
    logic [XLEN-1:0]  frame_addr;

    assign idle       = (state_q == ST_IDLE);
    assign misaligned = |sp_q[WB_SHIFT-1:0];

    ctx_start_arb #(.XLEN(XLEN), .LEN_W(LEN_W)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .idle        (idle),
        .irq_req     (irq_req),
        .call_start  (call_start),
        .ret_start   (ret_start),
        .call_target (call_target),
        .call_len    (call_len),
        .go          (arb_go),
        .go_op       (arb_op),
        .go_tgt      (arb_tgt),
        .go_len      (arb_len)
    );

    ctx_frame_addr #(.XLEN(XLEN), .IDX_W(RF_AW), .WB_SHIFT(WB_SHIFT)) u_addr (
        .sp     (sp_q),
        .idx    (idx_q),
        .upward (state_q == ST_LOAD),
        .addr   (frame_addr)
    );

    // Datapath toward memory and register file
    always_comb begin
        mem_req   = (state_q == ST_SAVE) || (state_q == ST_VEC) || (state_q == ST_LOAD);
        mem_we    = (state_q == ST_SAVE);
        mem_addr  = (state_q == ST_VEC) ? VEC_ADDR : frame_addr;
        rf_addr   = (state_q == ST_LOAD) ? (LAST_IDX - idx_q) : idx_q;
        mem_wdata = (idx_q == '0) ? ret_pc_q : rf_rdata;
        rf_we     = (state_q == ST_LOAD) && mem_ack && (idx_q != LAST_IDX);
        rf_wdata  = mem_rdata;
        done      = (state_q == ST_FIN) || (state_q == ST_ERR);
        err       = (state_q == ST_ERR);
        pc_o      = pc_q;
        sp_o      = sp_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            op_q     <= OP_CALL;
            idx_q    <= '0;
            tgt_q    <= '0;
            ret_pc_q <= '0;
            pc_q     <= '0;
            sp_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (arb_go) begin
                        op_q     <= arb_op;
                        tgt_q    <= arb_tgt;
                        idx_q    <= '0;
                        ret_pc_q <= (arb_op == OP_CALL)
                                    ? pc_q + {{(XLEN-LEN_W){1'b0}}, arb_len}
                                    : pc_q;
                        if (misaligned)
                            state_q <= ST_ERR;
                        else if (op_saves(arb_op))
                            state_q <= ST_SAVE;
                        else
                            state_q <= ST_LOAD;
                    end else if (arch_load) begin
                        pc_q <= arch_pc;
                        sp_q <= arch_sp;
                    end
                end
                ST_SAVE: begin
                    if (mem_ack) begin
                        if (idx_q == LAST_IDX) begin
                            idx_q <= '0;
                            sp_q  <= sp_q - FRAME_BYTES;
                            if (op_q == OP_IRQ) begin
                                state_q <= ST_VEC;
                            end else begin
                                pc_q    <= tgt_q;
                                state_q <= ST_FIN;
                            end
                        end else begin
                            idx_q <= idx_q + RF_AW'(1);
                        end
                    end
                end
                ST_VEC: begin
                    if (mem_ack) begin
                        pc_q    <= mem_rdata;
                        state_q <= ST_FIN;
                    end
                end
                ST_LOAD: begin
                    if (mem_ack) begin
                        if (idx_q == LAST_IDX) begin
                            idx_q   <= '0;
                            pc_q    <= mem_rdata;
                            sp_q    <= sp_q + FRAME_BYTES;
                            state_q <= ST_FIN;
                        end else begin
                            idx_q <= idx_q + RF_AW'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)))
        else $error("request dropped or changed before ack"); // R6

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[WB_SHIFT-1:0] == '0)) else $error("unaligned access"); // R1

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R7

    AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (idle && arb_go && misaligned) |=> (err && done && !mem_req)) else $error("misaligned start not flagged"); // R9

    AST_RF_WRITE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (mem_req && !mem_we && mem_ack)) else $error("register write without read ack"); // R4

    AST_IRQ_BEATS_CALL: assert property (@(posedge clk) disable iff (rst)
        (idle && $past(state_q) == ST_IDLE && irq_req && call_start && !misaligned)
        |=> (state_q == ST_SAVE && op_q == OP_IRQ)) else $error("call taken before interrupt"); // R8

endmodule

// File: tb/tb_ctx_seq.sv
module tb_ctx_seq;

    localparam int          CLK_PERIOD = 10;
    localparam int          XLEN       = 64;
    localparam int          LEN_W      = 4;
    localparam logic [63:0] VEC        = 64'h0;
    localparam logic [63:0] HANDLER    = 64'h9000;
    localparam int          WATCHDOG   = 50000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             arch_load = 1'b0;
    logic [63:0]      arch_pc = '0, arch_sp = '0;
    logic             call_start = 1'b0, ret_start = 1'b0, irq_req = 1'b0;
    logic [63:0]      call_target = '0;
    logic [LEN_W-1:0] call_len = '0;
    logic [3:0]       rf_addr;
    logic [63:0]      rf_rdata, rf_wdata;
    logic             rf_we;
    logic             mem_req, mem_we;
    logic [63:0]      mem_addr, mem_wdata;
    logic [63:0]      mem_rdata = '0;
    logic             mem_ack = 1'b0;
    logic [63:0]      pc_o, sp_o;
    logic             done, err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    ctx_seq #(.XLEN(XLEN), .NREG(15), .LEN_W(LEN_W), .VEC_ADDR(VEC)) dut (
        .clk(clk), .rst(rst),
        .arch_load(arch_load), .arch_pc(arch_pc), .arch_sp(arch_sp),
        .call_start(call_start), .call_target(call_target), .call_len(call_len),
        .ret_start(ret_start), .irq_req(irq_req),
        .rf_addr(rf_addr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .pc_o(pc_o), .sp_o(sp_o), .done(done), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Register-file model
    logic [63:0] rf [0:15];
    logic        rf_fill = 1'b0;
    logic [63:0] fill_base = 64'hA000_0000_0000_0000;
    assign rf_rdata = rf[rf_addr];

    always @(posedge clk) begin
        if (rst || rf_fill) begin
            for (int i = 0; i < 16; i++) rf[i] <= fill_base + 64'(i);
        end else if (rf_we) begin
            rf[rf_addr] <= rf_wdata;
        end
    end

    // Scoreboard of expected memory accesses
    typedef struct packed {
        logic        we;
        logic        chk_data;
        logic [63:0] addr;
        logic [63:0] data;
    } txn_t;
    txn_t  exp_q[$];
    string tag_q[$];

    task automatic push(input logic we, input logic cd, input logic [63:0] a,
                        input logic [63:0] d, input string tag);
        txn_t t;
        t.we = we; t.chk_data = cd; t.addr = a; t.data = d;
        exp_q.push_back(t);
        tag_q.push_back(tag);
    endtask

    // R1 frame layout: PC at SP-8, register i at SP-8*(i+1)
    task automatic exp_save(input logic [63:0] sp0, input logic [63:0] saved_pc,
                            input logic [63:0] base, input string tag);
        push(1'b1, 1'b1, sp0 - 64'd8, saved_pc, tag);
        for (int i = 1; i <= 15; i++)
            push(1'b1, 1'b1, sp0 - 64'(8 * (i + 1)), base + 64'(i), "R1");
    endtask

    // R4 restore walks upward from the top of stack
    task automatic exp_restore(input logic [63:0] top);
        for (int j = 0; j < 16; j++)
            push(1'b0, 1'b0, top + 64'(8 * j), 64'h0, "R4");
    endtask

    logic [63:0] mem [logic [63:0]];
    int          wait_cnt = 0;
    int          txn_cnt  = 0;

    // Memory model and monitor
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0;
            wait_cnt = 0;
            mem[VEC] = HANDLER;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt != 0) begin
                wait_cnt--;
            end else begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected access addr", mem_addr, 64'h0);
                end else begin
                    txn_t  e;
                    string tg;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    chk(mem_we == e.we, tg, "access direction", 64'(mem_we), 64'(e.we));
                    chk(mem_addr == e.addr, tg, "access address", mem_addr, e.addr);
                    if (e.chk_data)
                        chk(mem_wdata == e.data, tg, "write data", mem_wdata, e.data);
                end
                if (mem_we) mem[mem_addr] = mem_wdata;
                else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
                mem_ack = 1'b1;
                txn_cnt++;
                wait_cnt = txn_cnt % 3;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                chk(1'b0, "R7", "watchdog expired", 64'(cyc), 64'(WATCHDOG));
                finish_run();
            end
        end
    end

    task automatic do_load(input logic [63:0] p, input logic [63:0] s);
        @(negedge clk); arch_load = 1'b1; arch_pc = p; arch_sp = s;
        @(negedge clk); arch_load = 1'b0;
    endtask

    task automatic do_fill(input logic [63:0] base);
        @(negedge clk); rf_fill = 1'b1; fill_base = base;
        @(negedge clk); rf_fill = 1'b0;
    endtask

    task automatic pulse(input bit c, input bit r, input bit q,
                         input logic [63:0] tgt, input logic [LEN_W-1:0] len);
        @(negedge clk);
        call_start = c; ret_start = r; irq_req = q; call_target = tgt; call_len = len;
        @(negedge clk);
        call_start = 1'b0; ret_start = 1'b0; irq_req = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 500) begin
            @(posedge clk); #1;
            n++;
        end
        chk(done == 1'b1, req, "done seen", 64'(done), 64'h1);
    endtask

    task automatic done_drops();
        @(posedge clk); #1;
        chk(done == 1'b0, "R7", "done one cycle only", 64'(done), 64'h0);
    endtask

    task automatic chk_pcsp(input string req, input logic [63:0] p, input logic [63:0] s);
        chk(pc_o == p, req, "pc", pc_o, p);
        chk(sp_o == s, req, "sp", sp_o, s);
    endtask

    task automatic chk_regs(input string req, input logic [63:0] base);
        for (int i = 1; i <= 15; i++)
            chk(rf[i] == base + 64'(i), req, $sformatf("register %0d restored", i), rf[i], base + 64'(i));
    endtask

    localparam logic [63:0] BASE_A = 64'hA000_0000_0000_0000;
    localparam logic [63:0] BASE_B = 64'hB000_0000_0000_0000;
    localparam logic [63:0] BASE_C = 64'hC000_0000_0000_0000;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R10 reset state
        chk_pcsp("R10", 64'h0, 64'h0);
        chk(done == 1'b0, "R10", "done after reset", 64'(done), 64'h0);
        chk(err == 1'b0, "R10", "err after reset", 64'(err), 64'h0);
        chk(mem_req == 1'b0, "R10", "mem_req after reset", 64'(mem_req), 64'h0);

        do_load(64'h1000, 64'h8000);
        chk_pcsp("R10", 64'h1000, 64'h8000);

        // R1 R2 R3: first call
        exp_save(64'h8000, 64'h1005, BASE_A, "R2");
        pulse(1'b1, 1'b0, 1'b0, 64'h2000, 4'd5);
        wait_done("R3");
        chk_pcsp("R3", 64'h2000, 64'h7F80);
        chk(err == 1'b0, "R3", "no error", 64'(err), 64'h0);
        done_drops();

        // R7: nested call with a return raised while busy
        do_fill(BASE_B);
        exp_save(64'h7F80, 64'h2003, BASE_B, "R2");
        pulse(1'b1, 1'b0, 1'b0, 64'h3000, 4'd3);
        pulse(1'b0, 1'b1, 1'b0, 64'h0, 4'd0);
        wait_done("R7");
        chk_pcsp("R7", 64'h3000, 64'h7F00);
        done_drops();
        repeat (6) @(posedge clk);
        #1;
        chk(mem_req == 1'b0, "R7", "no access after ignored start", 64'(mem_req), 64'h0);
        chk(exp_q.size() == 0, "R1", "all saves seen", 64'(exp_q.size()), 64'h0);

        // R4: two returns unwind the nest
        do_fill(BASE_C);
        exp_restore(64'h7F00);
        pulse(1'b0, 1'b1, 1'b0, 64'h0, 4'd0);
        wait_done("R4");
        chk_pcsp("R4", 64'h2003, 64'h7F80);
        chk_regs("R4", BASE_B);
        done_drops();

        exp_restore(64'h7F80);
        pulse(1'b0, 1'b1, 1'b0, 64'h0, 4'd0);
        wait_done("R4");
        chk_pcsp("R4", 64'h1005, 64'h8000);
        chk_regs("R4", BASE_A);
        done_drops();

        // R5 and R2: interrupt saves PC unchanged, then reads the vector
        exp_save(64'h8000, 64'h1005, BASE_A, "R2");
        push(1'b0, 1'b0, VEC, 64'h0, "R5");
        pulse(1'b0, 1'b0, 1'b1, 64'h0, 4'd0);
        wait_done("R5");
        chk_pcsp("R5", HANDLER, 64'h7F80);
        done_drops();

        exp_restore(64'h7F80);
        pulse(1'b0, 1'b1, 1'b0, 64'h0, 4'd0);
        wait_done("R4");
        chk_pcsp("R4", 64'h1005, 64'h8000);
        done_drops();

        // R8: interrupt and call in the same cycle
        exp_save(64'h8000, 64'h1005, BASE_A, "R8");
        push(1'b0, 1'b0, VEC, 64'h0, "R8");
        exp_save(64'h7F80, HANDLER + 64'd2, BASE_A, "R8");
        pulse(1'b1, 1'b0, 1'b1, 64'h4000, 4'd2);
        wait_done("R8");
        chk_pcsp("R8", HANDLER, 64'h7F80);
        done_drops();
        wait_done("R8");
        chk_pcsp("R8", 64'h4000, 64'h7F00);
        done_drops();
        chk(exp_q.size() == 0, "R8", "deferred call complete", 64'(exp_q.size()), 64'h0);

        // R9: misaligned stack pointer
        do_load(64'h5000, 64'h8004);
        pulse(1'b1, 1'b0, 1'b0, 64'h6000, 4'd4);
        wait_done("R9");
        chk(err == 1'b1, "R9", "err with done", 64'(err), 64'h1);
        chk_pcsp("R9", 64'h5000, 64'h8004);
        done_drops();
        repeat (4) @(posedge clk);
        #1;
        chk(mem_req == 1'b0, "R9", "no memory access", 64'(mem_req), 64'h0);
        chk_pcsp("R9", 64'h5000, 64'h8004);

        chk(exp_q.size() == 0, "R1", "scoreboard drained", 64'(exp_q.size()), 64'h0);
        finish_run();
    end

endmodule